// File: doc/BRIEF.md
# Inter-access idle cycle inserter

This block sits between the access sequencer of an external bus controller and the logic that drives the pins. When two external accesses follow each other, it decides how many idle bus cycles must separate them, and it withholds the start strobe of the second access until that many cycles have passed since the first one ended. Read buffers in slow devices switch off late. The idle cycles keep the next data phase from colliding with a device that is still driving the bus.

Every chip-select space has its own five idle-count fields. The count that applies is chosen from the previous access and the pending one. The inputs are the direction of each access (read or write), whether both accesses target the same space, and whether the previous access was a DMA single transfer in which an external device drove the data. One shared field and one mode bit cover that DMA case. While the count runs, a busy output tells surrounding logic that the bus cycle is still in progress, even though no strobe is visible on the pins.

The sequencer presents a request with its attributes and keeps it valid until it sees `start_o`. It signals the last cycle of the running access with a one-cycle `acc_end_i` pulse. Idle cycles are counted from the cycle after that pulse.

Top module: `idle_gap_inserter`

## Requirements
- R1: After reset there is no previous access, so the first request starts in the cycle it is presented, with zero idle cycles.
- R2: If the previous access was a write, the next access (read or write) waits the count in bits [1:0] of the previous space's 10-bit field group.
- R3: If a read is followed by a write, the count comes from bits [3:2] of that group when the spaces differ and from bits [5:4] when they are the same.
- R4: If a read is followed by a read, the count comes from bits [7:6] of that group when the spaces differ and from bits [9:8] when they are the same.
- R5: Space s owns bits [10*s+9 : 10*s] of `cfg_idle_i`. The group that applies belongs to the space of the previous access, not the space of the next one.
- R6: Each 2-bit field encodes a count of idle cycles: 0 means 0, 1 means 1, 2 means 2 and 3 means 4.
- R7: When `cfg_dma_any_i` is 0, the DMA count in `cfg_dma_idle_i` applies after an access flagged `req_dma_ext_i` only if the next access is not also flagged `req_dma_ext_i`.
- R8: When `cfg_dma_any_i` is 1, the DMA count applies after an access flagged `req_dma_ext_i`, whatever the next access is.
- R9: When both the direction/space count and the DMA count apply, the larger of the two is inserted.
- R10: `busy_o` is high in every cycle in which a request is pending but held back by idle counting. It is low in the cycle `start_o` is given.
- R11: Idle cycles are counted from the cycle after `acc_end_i`. A request that arrives after enough idle cycles have already passed starts at once.
- R12: `start_o` is given at most once per access. It is never high while an access is running, that is, from the cycle after `start_o` through the cycle of `acc_end_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_idle_i | input | 10*NUM_SPACES | Per-space idle-count field groups |
| cfg_dma_idle_i | input | 2 | Idle-count code for the DMA single-transfer case |
| cfg_dma_any_i | input | 1 | DMA count mode: 0 = only before a non-DMA access, 1 = before any access |
| req_valid_i | input | 1 | Next access is pending |
| req_write_i | input | 1 | Pending access is a write |
| req_space_i | input | SPACE_W | Chip-select space of the pending access |
| req_dma_ext_i | input | 1 | Pending access is a DMA single transfer with an external data driver |
| acc_end_i | input | 1 | Last cycle of the running access |
| start_o | output | 1 | Start strobe for the pending access |
| busy_o | output | 1 | Idle cycles are being counted for a pending request |

## Verification
The bench steps through each direction pair in the same space and in different spaces, so that a design that took the field group of the next space, or swapped the same-space and different-space fields, would hold the strobe for the wrong number of cycles. Code 3 is used where a design that decoded it as 3 would start one cycle early. The DMA cases are run in both modes, including back-to-back DMA transfers where mode 0 must not apply the DMA count, and cases where the DMA count and the direction count each win in turn; this catches a design that adds the two counts or takes the wrong one. A late request after a saturated gap must start at once, and a held request must not receive a second strobe during its own access.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

    localparam int CODE_W      = 2;
    localparam int FIELDS      = 5;
    localparam int GROUP_W     = CODE_W * FIELDS;
    localparam int COUNT_W     = 3;
    localparam int MAX_IDLE    = 4;

    // position of each field inside one space's group
    typedef enum logic [2:0] {
        FLD_AFTER_WRITE = 3'd0,
        FLD_RW_DIFF     = 3'd1,
        FLD_RW_SAME     = 3'd2,
        FLD_RR_DIFF     = 3'd3,
        FLD_RR_SAME     = 3'd4
    } field_e;

    function automatic logic [COUNT_W-1:0] decode_idle(input logic [CODE_W-1:0] code);
        logic [COUNT_W-1:0] cnt;
        case (code)
            2'd0:    cnt = 3'd0;
            2'd1:    cnt = 3'd1;
            2'd2:    cnt = 3'd2;
            default: cnt = 3'd4;
        endcase
        return cnt;
    endfunction

endpackage

// File: rtl/idle_need_calc.sv
module idle_need_calc
    import idle_gap_pkg::*;
#(
    parameter int NUM_SPACES = 4,
    parameter int SPACE_W    = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1
) (
    input  logic [GROUP_W*NUM_SPACES-1:0] cfg_idle_i,
    input  logic [CODE_W-1:0]             cfg_dma_idle_i,
    input  logic                          cfg_dma_any_i,
    input  logic                          has_prev_i,
    input  logic                          prev_write_i,
    input  logic [SPACE_W-1:0]            prev_space_i,
    input  logic                          prev_dma_i,
    input  logic                          nxt_write_i,
    input  logic [SPACE_W-1:0]            nxt_space_i,
    input  logic                          nxt_dma_i,
    output logic [COUNT_W-1:0]            need_o
);

    logic [GROUP_W-1:0] group_a [NUM_SPACES];

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_unpack
        assign group_a[s] = cfg_idle_i[s*GROUP_W +: GROUP_W];
    end

    logic [GROUP_W-1:0] prev_group;
    field_e             fld;
    logic [CODE_W-1:0]  cls_code;
    logic [COUNT_W-1:0] cls_cnt;
    logic [COUNT_W-1:0] dma_cnt;
    logic               dma_hit;
    logic               same_space;

    always_comb begin
        prev_group = '0;
        if (32'(prev_space_i) < NUM_SPACES) begin
            prev_group = group_a[prev_space_i];
        end

        same_space = (prev_space_i == nxt_space_i);

        if (prev_write_i) begin
            fld = FLD_AFTER_WRITE;
        end else if (nxt_write_i) begin
            fld = same_space ? FLD_RW_SAME : FLD_RW_DIFF;
        end else begin
            fld = same_space ? FLD_RR_SAME : FLD_RR_DIFF;
        end

        cls_code = prev_group[32'(fld)*CODE_W +: CODE_W];
        cls_cnt  = decode_idle(cls_code);

        dma_hit  = prev_dma_i && (cfg_dma_any_i || !nxt_dma_i);
        dma_cnt  = dma_hit ? decode_idle(cfg_dma_idle_i) : '0;

        if (!has_prev_i) begin
            need_o = '0;
        end else if (dma_cnt > cls_cnt) begin
            need_o = dma_cnt;
        end else begin
            need_o = cls_cnt;
        end
    end

endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer
    import idle_gap_pkg::*;
#(
    parameter int SAT = MAX_IDLE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               run_i,
    output logic [COUNT_W-1:0] gap_o
);

    typedef struct packed {
        logic [COUNT_W-1:0] gap;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear_i) begin
            tmr_d.gap = '0;
        end else if (run_i && (32'(tmr_q.gap) < SAT)) begin
            tmr_d.gap = tmr_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign gap_o = tmr_q.gap;

    AST_GAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && run_i && (32'(gap_o) < SAT)) |=> (gap_o == $past(gap_o) + 1'b1)) // R11
        else $error("idle gap counter did not advance");

    AST_GAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (gap_o == '0)) // R11
        else $error("idle gap counter not cleared at access end");

endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
    import idle_gap_pkg::*;
#(
    parameter int NUM_SPACES = 4,
    parameter int SPACE_W    = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [10*NUM_SPACES-1:0]           cfg_idle_i,
    input  logic [1:0]                         cfg_dma_idle_i,
    input  logic                               cfg_dma_any_i,
    input  logic                               req_valid_i,
    input  logic                               req_write_i,
    input  logic [SPACE_W-1:0]                 req_space_i,
    input  logic                               req_dma_ext_i,
    input  logic                               acc_end_i,
    output logic                               start_o,
    output logic                               busy_o
);

    typedef struct packed {
        logic               in_access;
        logic               has_prev;
        logic               prev_write;
        logic               prev_dma;
        logic [SPACE_W-1:0] prev_space;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [COUNT_W-1:0] need;
    logic [COUNT_W-1:0] gap;
    logic               waiting;
    logic               grant;

    idle_need_calc #(
        .NUM_SPACES (NUM_SPACES),
        .SPACE_W    (SPACE_W)
    ) u_need (
        .cfg_idle_i     (cfg_idle_i),
        .cfg_dma_idle_i (cfg_dma_idle_i),
        .cfg_dma_any_i  (cfg_dma_any_i),
        .has_prev_i     (seq_q.has_prev),
        .prev_write_i   (seq_q.prev_write),
        .prev_space_i   (seq_q.prev_space),
        .prev_dma_i     (seq_q.prev_dma),
        .nxt_write_i    (req_write_i),
        .nxt_space_i    (req_space_i),
        .nxt_dma_i      (req_dma_ext_i),
        .need_o         (need)
    );

    idle_gap_timer #(
        .SAT (MAX_IDLE)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (acc_end_i),
        .run_i   (!seq_q.in_access),
        .gap_o   (gap)
    );

    always_comb begin
        seq_d   = seq_q;
        waiting = req_valid_i && !seq_q.in_access && (gap < need);
        grant   = req_valid_i && !seq_q.in_access && (gap >= need);

        if (grant) begin
            seq_d.in_access  = 1'b1;
            seq_d.has_prev   = 1'b1;
            seq_d.prev_write = req_write_i;
            seq_d.prev_dma   = req_dma_ext_i;
            seq_d.prev_space = req_space_i;
        end else if (acc_end_i) begin
            seq_d.in_access  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign start_o = grant;
    assign busy_o  = waiting;

    AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.has_prev |-> (need == '0)) // R1
        else $error("nonzero idle count with no previous access");

    AST_NEED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (need == 3'd0) || (need == 3'd1) || (need == 3'd2) || (need == 3'd4)) // R6
        else $error("idle count outside the encodable set");

    AST_DMA_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.has_prev && seq_q.prev_dma && cfg_dma_any_i)
            |-> (need >= decode_idle(cfg_dma_idle_i))) // R8
        else $error("DMA idle count not honoured in any-access mode");

    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_o) // R10
        else $error("busy and start together");

    AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o) // R12
        else $error("second start strobe for one access");

    AST_END_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_end_i |-> seq_q.in_access) // R12
        else $error("access end without a running access");

endmodule

// File: tb/tb_idle_gap_inserter.sv
module tb_idle_gap_inserter;

    localparam int NSP = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [10*NSP-1:0] cfg_idle = '0;
    logic [1:0]        cfg_dma_idle = 2'd0;
    logic              cfg_dma_any = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [1:0]        req_space = '0;
    logic              req_dma = 1'b0;
    logic              acc_end = 1'b0;
    logic              start_o;
    logic              busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    idle_gap_inserter #(.NUM_SPACES(NSP)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_idle_i     (cfg_idle),
        .cfg_dma_idle_i (cfg_dma_idle),
        .cfg_dma_any_i  (cfg_dma_any),
        .req_valid_i    (req_valid),
        .req_write_i    (req_write),
        .req_space_i    (req_space),
        .req_dma_ext_i  (req_dma),
        .acc_end_i      (acc_end),
        .start_o        (start_o),
        .busy_o         (busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // present one access, count idle cycles until start, then run it for one cycle
    task automatic issue(input logic w, input logic [1:0] sp, input logic d,
                         input int pre_delay, input int exp_wait, input string req);
        int  waited  = 0;
        bit  busy_ok = 1;
        repeat (pre_delay) @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_space = sp;
        req_dma   = d;
        #1;
        while (!start_o && waited < 10) begin
            if (!busy_o) busy_ok = 0;
            @(negedge clk);
            #1;
            waited++;
        end
        check(waited == exp_wait, req, waited, exp_wait);
        check(busy_o == 1'b0, "R10 busy low at start", int'(busy_o), 0);
        if (exp_wait > 0) check(busy_ok, "R10 busy held while waiting", int'(busy_ok), 1);
        @(negedge clk);
        acc_end = 1'b1;
        #1;
        check(start_o == 1'b0, "R12 no start during own access", int'(start_o), 0);
        @(negedge clk);
        acc_end   = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check(start_o == 1'b0, "R12 start low after reset", int'(start_o), 0);
        check(busy_o == 1'b0, "R10 busy low after reset", int'(busy_o), 0);
    endtask

    task automatic t_direction_pairs();
        issue(0, 2'd0, 0, 0, 0, "R1 first access no idle");
        issue(0, 2'd0, 0, 0, 2, "R4 read->read same space");
        issue(1, 2'd0, 0, 0, 4, "R3 R6 read->write same space code3");
        issue(0, 2'd1, 0, 0, 2, "R2 R5 write->read uses previous space");
        issue(0, 2'd0, 0, 0, 4, "R4 R5 read->read different space");
        issue(1, 2'd1, 0, 0, 1, "R3 read->write different space");
        issue(1, 2'd1, 0, 0, 1, "R2 write->write");
        issue(0, 2'd1, 0, 0, 1, "R2 write->read same space");
    endtask

    task automatic t_dma_modes();
        cfg_dma_idle = 2'd3;
        cfg_dma_any  = 1'b0;
        issue(0, 2'd1, 1, 0, 1, "R7 DMA count not used when previous is plain");
        issue(0, 2'd1, 1, 0, 1, "R7 mode0 DMA followed by DMA");
        issue(1, 2'd1, 0, 0, 4, "R7 R9 mode0 DMA followed by plain access");
        cfg_dma_any  = 1'b1;
        issue(0, 2'd1, 1, 0, 1, "R2 write->read before DMA transfer");
        issue(0, 2'd1, 1, 0, 4, "R8 R9 mode1 DMA followed by DMA");
        cfg_dma_idle = 2'd1;
        issue(0, 2'd0, 0, 0, 4, "R9 direction count larger than DMA count");
    endtask

    task automatic t_late_request();
        issue(1, 2'd0, 0, 6, 0, "R11 late request after saturated gap");
        #1;
        check(busy_o == 1'b0, "R10 busy low with no request", int'(busy_o), 0);
    endtask

    initial begin
        // space 0: {rr_same, rr_diff, rw_same, rw_diff, after_write}
        cfg_idle[9:0]   = {2'd2, 2'd0, 2'd3, 2'd1, 2'd2};
        // space 1
        cfg_idle[19:10] = {2'd1, 2'd3, 2'd0, 2'd2, 2'd1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(negedge clk);
        t_direction_pairs();
        t_dma_modes();
        t_late_request();
        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
        end
    end

endmodule